// File: doc/BRIEF.md
# Ethernet PHY Management Register File

This block holds the sixteen 16-bit management registers that a 10/100 Ethernet PHY exposes to its MAC. A management controller on the MAC side issues single-cycle commands made of a PHY address, a register index, write data and a write or read strobe. Reads return the addressed register one clock later, together with a link-fail flag. Writes update the register file, except where a register is read-only or the address is not this PHY's.

A link-up input from the line side keeps the link-status bit and the link-partner ability register up to date. A power-on reset and a software reset, requested through the control register, both reload the default contents. After a software reset the current link state is applied again at once.

The command interface uses plain strobes and has no back-pressure. Every command completes in the cycle its strobe is sampled, so the block never stalls the controller, and no ready signal exists. The read result stays on `rd_data` until the next read strobe, so the controller may sample it at any later time.

Top module: `phy_mgmt_regfile`

## Requirements
- R1: After power-on reset, reading own-address registers gives: index 0 (control) = 0x1000 (auto-negotiation enable, bit 12), index 1 (status) = 0x7868 (ability bits 14..11, preamble suppression bit 6, auto-negotiation complete bit 5, auto-negotiation ability bit 3, link bit 2 clear), index 2 = 0x2000, index 3 = 0x5C90, index 4 (advertisement) = 0x01E1, and every other index = 0x0000.
- R2: A write to register index 16 or above changes no register, and a read of such an index returns 0x0000.
- R3: A control write with bit 15 set reloads every register with its reset value and is not stored itself. A control write with bit 15 clear is stored exactly as written.
- R4: Writes to index 1 (status), index 2 and index 3 (identifiers) have no effect.
- R5: Indices 4 to 15 store whatever is written to them.
- R6: When the link-up input goes high, status bit 2 becomes 1 and index 5 (link-partner ability) gets the bits of 0x01E1 ORed in. The change is visible to a read issued from the second clock after the input changes.
- R7: When the link-up input goes low, status bit 2 becomes 0 and index 5 keeps only its bits 8..0 (AND with 0x01FF).
- R8: A software reset applies the current link state to the reloaded defaults, so with the link up, status reads 0x786C and index 5 reads 0x01E1 right after it.
- R9: Only PHY address 1 is answered. A read of any other address returns 0xFFFF, and a write to any other address is dropped.
- R10: `link_fail` is 0 after power-on reset. Each read strobe, whatever its address, loads it with the inverse of `link_up`, and it holds between reads.
- R11: `rd_data` shows the result one clock after the read strobe and holds it until the next read. A read issued in the same cycle as a write to that register returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| link_up | input | 1 | Line-side link state, 1 = up |
| cmd_phy_addr | input | 5 | PHY address of the command |
| cmd_reg_addr | input | 5 | Register index of the command |
| cmd_wdata | input | 16 | Write data |
| cmd_wr | input | 1 | Write strobe, one cycle per command |
| cmd_rd | input | 1 | Read strobe, one cycle per command |
| rd_data | output | 16 | Read result, held until the next read |
| link_fail | output | 1 | Inverse of link state captured at the last read |

## Verification
The bench builds the block with its defaults: PHY address 1, sixteen registers and 5-bit address fields. With these values the upper half of the register index space (16 to 31) is reachable, so out-of-range writes and reads are checked. So are the lower indices that the same low four bits would alias onto, and foreign PHY addresses on both sides of the own one. Link transitions are driven around a pre-loaded link-partner register, so the OR on link-up and the mask on link-down produce values that differ from the defaults. The same-cycle read-and-write ordering is also checked.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
  localparam int unsigned MII_DW = 16;
  typedef logic [MII_DW-1:0] mii_word_t;

  // Register indices whose behaviour is special
  localparam int unsigned IDX_CTRL = 0;
  localparam int unsigned IDX_STAT = 1;
  localparam int unsigned IDX_ID_HI = 2;
  localparam int unsigned IDX_ID_LO = 3;
  localparam int unsigned IDX_ADV = 4;
  localparam int unsigned IDX_LPA = 5;

  // Bit positions
  localparam int unsigned CTRL_RST_BIT = 15;
  localparam int unsigned CTRL_ANEN_BIT = 12;
  localparam int unsigned STAT_LINK_BIT = 2;

  // Reset and link-update values
  localparam mii_word_t CTRL_DEFAULT = mii_word_t'(1) << CTRL_ANEN_BIT;
  localparam mii_word_t STAT_DEFAULT = 16'h7868;
  localparam mii_word_t ADV_DEFAULT = 16'h01E1;
  localparam mii_word_t LPA_UP_SET = 16'h01E1;
  localparam mii_word_t LPA_DOWN_KEEP = 16'h01FF;
endpackage

// File: rtl/mgmt_cmd_decode.sv
module mgmt_cmd_decode
  import phy_mgmt_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned PHY_ADDR = 1,
  localparam int unsigned IDX_W = $clog2(NUM_REGS)
) (
  input  logic [ADDR_W-1:0] phy_addr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              wr,
  input  logic              ctrl_rst_bit,
  output logic              own,
  output logic              idx_ok,
  output logic [IDX_W-1:0]  idx,
  output logic [NUM_REGS-1:0] wr_en,
  output logic              soft_rst
);
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(NUM_REGS);

  assign own    = (phy_addr == ADDR_W'(PHY_ADDR));
  assign idx_ok = ({1'b0, reg_addr} < LIMIT);
  assign idx    = reg_addr[IDX_W-1:0];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_wen
    assign wr_en[i] = wr && own && idx_ok && (idx == IDX_W'(i));
  end

  assign soft_rst = wr_en[IDX_CTRL] && ctrl_rst_bit;
endmodule

// File: rtl/mgmt_reg_bank.sv
module mgmt_reg_bank
  import phy_mgmt_pkg::*;
#(
  parameter int unsigned NUM_REGS = 16,
  parameter logic [15:0] ID_HI = 16'h2000,
  parameter logic [15:0] ID_LO = 16'h5C90
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_REGS-1:0]  wr_en,
  input  mii_word_t            wdata,
  input  logic                 soft_rst,
  input  logic                 link_up,
  output mii_word_t [NUM_REGS-1:0] regs_q
);
  function automatic mii_word_t def_val(int unsigned i);
    case (i)
      IDX_CTRL:  return CTRL_DEFAULT;
      IDX_STAT:  return STAT_DEFAULT;
      IDX_ID_HI: return ID_HI;
      IDX_ID_LO: return ID_LO;
      IDX_ADV:   return ADV_DEFAULT;
      default:   return '0;
    endcase
  endfunction

  function automatic bit is_ro(int unsigned i);
    return (i == IDX_STAT) || (i == IDX_ID_HI) || (i == IDX_ID_LO);
  endfunction

  logic link_q;
  logic link_apply;

  // Link edge or software reset both (re)apply the link state
  assign link_apply = soft_rst || (link_up != link_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) link_q <= 1'b0;
    else        link_q <= link_up;
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    mii_word_t base;
    mii_word_t nxt;

    always_comb begin
      if (soft_rst)                      base = def_val(i);
      else if (wr_en[i] && !is_ro(i))    base = wdata;
      else                               base = regs_q[i];
      nxt = base;
      if (link_apply) begin
        if (i == IDX_STAT) nxt[STAT_LINK_BIT] = link_up;
        if (i == IDX_LPA)  nxt = link_up ? (base | LPA_UP_SET) : (base & LPA_DOWN_KEEP);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs_q[i] <= def_val(i);
      else        regs_q[i] <= nxt;
    end
  end
endmodule

// File: rtl/mgmt_read_port.sv
module mgmt_read_port
  import phy_mgmt_pkg::*;
#(
  parameter int unsigned NUM_REGS = 16,
  localparam int unsigned IDX_W = $clog2(NUM_REGS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd,
  input  logic                 own,
  input  logic                 idx_ok,
  input  logic [IDX_W-1:0]     idx,
  input  mii_word_t [NUM_REGS-1:0] regs,
  input  logic                 link_up,
  output mii_word_t            rd_data,
  output logic                 link_fail
);
  mii_word_t sel;

  always_comb begin
    if (!own)        sel = '1;
    else if (idx_ok) sel = regs[idx];
    else             sel = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data   <= '0;
      link_fail <= 1'b0;
    end else if (rd) begin
      rd_data   <= sel;
      link_fail <= !link_up;
    end
  end
endmodule

// File: rtl/phy_mgmt_regfile.sv
module phy_mgmt_regfile
  import phy_mgmt_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned PHY_ADDR = 1,
  parameter logic [15:0] ID_HI = 16'h2000,
  parameter logic [15:0] ID_LO = 16'h5C90,
  localparam int unsigned IDX_W = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_up,
  input  logic [ADDR_W-1:0] cmd_phy_addr,
  input  logic [ADDR_W-1:0] cmd_reg_addr,
  input  logic [15:0]       cmd_wdata,
  input  logic              cmd_wr,
  input  logic              cmd_rd,
  output logic [15:0]       rd_data,
  output logic              link_fail
);
  logic                     own;
  logic                     idx_ok;
  logic [IDX_W-1:0]         idx;
  logic [NUM_REGS-1:0]      wr_en;
  logic                     soft_rst;
  mii_word_t [NUM_REGS-1:0] reg_q;

  mgmt_cmd_decode #(
    .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .PHY_ADDR(PHY_ADDR)
  ) u_dec (
    .phy_addr(cmd_phy_addr), .reg_addr(cmd_reg_addr), .wr(cmd_wr),
    .ctrl_rst_bit(cmd_wdata[CTRL_RST_BIT]),
    .own(own), .idx_ok(idx_ok), .idx(idx), .wr_en(wr_en), .soft_rst(soft_rst)
  );

  mgmt_reg_bank #(
    .NUM_REGS(NUM_REGS), .ID_HI(ID_HI), .ID_LO(ID_LO)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(cmd_wdata),
    .soft_rst(soft_rst), .link_up(link_up), .regs_q(reg_q)
  );

  mgmt_read_port #(
    .NUM_REGS(NUM_REGS)
  ) u_rd (
    .clk(clk), .rst_n(rst_n), .rd(cmd_rd), .own(own), .idx_ok(idx_ok),
    .idx(idx), .regs(reg_q), .link_up(link_up),
    .rd_data(rd_data), .link_fail(link_fail)
  );
endmodule

// File: rtl/phy_mgmt_checker.sv
module phy_mgmt_checker
  import phy_mgmt_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned PHY_ADDR = 1,
  parameter logic [15:0] ID_HI = 16'h2000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              link_up,
  input logic [ADDR_W-1:0] cmd_phy_addr,
  input logic [ADDR_W-1:0] cmd_reg_addr,
  input logic [15:0]       cmd_wdata,
  input logic              cmd_wr,
  input logic              cmd_rd,
  input logic [15:0]       rd_data,
  input logic              link_fail,
  input mii_word_t [NUM_REGS-1:0] regs
);
  logic own_c;
  assign own_c = (cmd_phy_addr == ADDR_W'(PHY_ADDR));

  AST_FOREIGN_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rd && !own_c |=> rd_data == 16'hFFFF); // R9

  AST_LINKFAIL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rd |=> link_fail == !$past(link_up)); // R10

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_rd |=> $stable(rd_data) && $stable(link_fail)); // R11

  AST_ID_READONLY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rd && own_c && cmd_reg_addr == ADDR_W'(IDX_ID_HI) |=> rd_data == ID_HI); // R4

  AST_SOFT_RESET_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && own_c && cmd_reg_addr == ADDR_W'(IDX_CTRL) && cmd_wdata[CTRL_RST_BIT]
    |=> regs[IDX_CTRL] == CTRL_DEFAULT); // R3

  AST_CTRL_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && own_c && cmd_reg_addr == ADDR_W'(IDX_CTRL) && !cmd_wdata[CTRL_RST_BIT]
    |=> regs[IDX_CTRL] == $past(cmd_wdata)); // R3

  AST_STATUS_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> regs[IDX_STAT][STAT_LINK_BIT] == $past(link_up)); // R6

  AST_LPA_MASK_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(link_up) |=> regs[IDX_LPA][15:9] == 7'd0); // R7
endmodule

bind phy_mgmt_regfile phy_mgmt_checker #(
  .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .PHY_ADDR(PHY_ADDR), .ID_HI(ID_HI)
) u_chk (
  .clk(clk), .rst_n(rst_n), .link_up(link_up), .cmd_phy_addr(cmd_phy_addr),
  .cmd_reg_addr(cmd_reg_addr), .cmd_wdata(cmd_wdata), .cmd_wr(cmd_wr),
  .cmd_rd(cmd_rd), .rd_data(rd_data), .link_fail(link_fail), .regs(reg_q)
);

// File: tb/phy_mgmt_regfile_bench.sv
`timescale 1ns/1ps
module phy_mgmt_regfile_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        link_up = 1'b0;
  logic [4:0]  cmd_phy_addr = '0;
  logic [4:0]  cmd_reg_addr = '0;
  logic [15:0] cmd_wdata = '0;
  logic        cmd_wr = 1'b0;
  logic        cmd_rd = 1'b0;
  logic [15:0] rd_data;
  logic        link_fail;

  int checks = 0;
  int failures = 0;

  logic [15:0] exp_data[$];
  logic        exp_lf[$];
  string       exp_tag[$];
  logic        rd_seen = 1'b0;

  always #5 clk = ~clk;

  phy_mgmt_regfile u_phy_mgmt_regfile (
    .clk(clk), .rst_n(rst_n), .link_up(link_up), .cmd_phy_addr(cmd_phy_addr),
    .cmd_reg_addr(cmd_reg_addr), .cmd_wdata(cmd_wdata), .cmd_wr(cmd_wr),
    .cmd_rd(cmd_rd), .rd_data(rd_data), .link_fail(link_fail)
  );

  task automatic check(input bit ok, input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", tag, act, exp);
    end
  endtask

  // Driver tasks: strobes are raised on a falling edge for one cycle
  task automatic do_write(input logic [4:0] phy, input logic [4:0] ra,
                          input logic [15:0] d);
    @(negedge clk);
    cmd_phy_addr = phy; cmd_reg_addr = ra; cmd_wdata = d; cmd_wr = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0;
  endtask

  task automatic do_read(input logic [4:0] phy, input logic [4:0] ra,
                         input logic [15:0] exp, input string tag);
    @(negedge clk);
    cmd_phy_addr = phy; cmd_reg_addr = ra; cmd_rd = 1'b1;
    exp_data.push_back(exp); exp_lf.push_back(!link_up); exp_tag.push_back(tag);
    @(negedge clk);
    cmd_rd = 1'b0;
  endtask

  task automatic do_wr_rd(input logic [4:0] ra, input logic [15:0] d,
                          input logic [15:0] exp, input string tag);
    @(negedge clk);
    cmd_phy_addr = 5'd1; cmd_reg_addr = ra; cmd_wdata = d;
    cmd_wr = 1'b1; cmd_rd = 1'b1;
    exp_data.push_back(exp); exp_lf.push_back(!link_up); exp_tag.push_back(tag);
    @(negedge clk);
    cmd_wr = 1'b0; cmd_rd = 1'b0;
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Monitor: pops expectations one clock after each read strobe
  always @(posedge clk) rd_seen <= cmd_rd;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_data.size() == 0) begin
        check(1'b0, "R11 unexpected read result", rd_data, 16'h0);
      end else begin
        logic [15:0] ed;
        logic        el;
        string       et;
        ed = exp_data.pop_front(); el = exp_lf.pop_front(); et = exp_tag.pop_front();
        check(rd_data === ed, et, rd_data, ed);
        check(link_fail === el, {et, " R10 link_fail"}, {15'd0, link_fail}, {15'd0, el});
      end
    end
  end

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired actual=0x0000 expected=0x0001");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait_cycles(3);
    rst_n = 1'b1;
    @(negedge clk);
    check(link_fail === 1'b0, "R10 link_fail after reset", {15'd0, link_fail}, 16'h0);
    check(rd_data === 16'h0, "R1 rd_data after reset", rd_data, 16'h0);

    // R1 defaults, link down
    do_read(5'd1, 5'd0, 16'h1000, "R1 control default");
    do_read(5'd1, 5'd1, 16'h7868, "R1 status default");
    do_read(5'd1, 5'd2, 16'h2000, "R1 id high");
    do_read(5'd1, 5'd3, 16'h5C90, "R1 id low");
    do_read(5'd1, 5'd4, 16'h01E1, "R1 advertisement default");
    do_read(5'd1, 5'd5, 16'h0000, "R1 partner default");
    do_read(5'd1, 5'd15, 16'h0000, "R1 top register default");

    // R5 writable registers
    do_write(5'd1, 5'd7, 16'hABCD);
    do_read(5'd1, 5'd7, 16'hABCD, "R5 store index 7");
    do_write(5'd1, 5'd15, 16'h1234);
    do_read(5'd1, 5'd15, 16'h1234, "R5 store index 15");
    do_write(5'd1, 5'd4, 16'h0021);
    do_read(5'd1, 5'd4, 16'h0021, "R5 store advertisement");

    // R4 read-only registers
    do_write(5'd1, 5'd1, 16'hFFFF);
    do_read(5'd1, 5'd1, 16'h7868, "R4 status read-only");
    do_write(5'd1, 5'd2, 16'h0000);
    do_read(5'd1, 5'd2, 16'h2000, "R4 id high read-only");
    do_write(5'd1, 5'd3, 16'h1111);
    do_read(5'd1, 5'd3, 16'h5C90, "R4 id low read-only");

    // R2 out of range: index 20 aliases index 4 on low bits, 23 aliases 7
    do_write(5'd1, 5'd20, 16'h5555);
    do_write(5'd1, 5'd23, 16'h6666);
    do_read(5'd1, 5'd4, 16'h0021, "R2 no alias to index 4");
    do_read(5'd1, 5'd7, 16'hABCD, "R2 no alias to index 7");
    do_read(5'd1, 5'd20, 16'h0000, "R2 read out of range");

    // R9 foreign addresses
    do_write(5'd2, 5'd7, 16'h0000);
    do_write(5'd0, 5'd15, 16'h0000);
    do_read(5'd1, 5'd7, 16'hABCD, "R9 foreign write dropped idx7");
    do_read(5'd1, 5'd15, 16'h1234, "R9 foreign write dropped idx15");
    do_read(5'd0, 5'd2, 16'hFFFF, "R9 foreign read addr 0");
    do_read(5'd31, 5'd4, 16'hFFFF, "R9 foreign read addr 31");

    // R6 link up over a pre-loaded partner register
    do_write(5'd1, 5'd5, 16'hFE00);
    @(negedge clk); link_up = 1'b1;
    wait_cycles(1);
    do_read(5'd1, 5'd1, 16'h786C, "R6 status link bit set");
    do_read(5'd1, 5'd5, 16'hFFE1, "R6 partner bits ORed");

    // R7 link down
    @(negedge clk); link_up = 1'b0;
    wait_cycles(1);
    do_read(5'd1, 5'd1, 16'h7868, "R7 status link bit clear");
    do_read(5'd1, 5'd5, 16'h01E1, "R7 partner masked to low 9 bits");

    // R3 control store and software reset, R8 link reapplied
    @(negedge clk); link_up = 1'b1;
    wait_cycles(1);
    do_write(5'd1, 5'd0, 16'h0140);
    do_read(5'd1, 5'd0, 16'h0140, "R3 control stored");
    do_write(5'd1, 5'd7, 16'h1111);
    do_write(5'd1, 5'd5, 16'h3000);
    do_write(5'd1, 5'd0, 16'h8140);
    do_read(5'd1, 5'd0, 16'h1000, "R3 reset bit not stored");
    do_read(5'd1, 5'd7, 16'h0000, "R3 index 7 reloaded");
    do_read(5'd1, 5'd4, 16'h01E1, "R3 advertisement reloaded");
    do_read(5'd1, 5'd1, 16'h786C, "R8 status link after soft reset");
    do_read(5'd1, 5'd5, 16'h01E1, "R8 partner after soft reset");

    // R11 same-cycle read and write, then hold
    do_wr_rd(5'd8, 16'hAAAA, 16'h0000, "R11 read sees old value");
    do_read(5'd1, 5'd8, 16'hAAAA, "R11 read sees new value");
    wait_cycles(4);
    check(rd_data === 16'hAAAA, "R11 rd_data held", rd_data, 16'hAAAA);
    @(negedge clk); link_up = 1'b0;
    wait_cycles(2);
    check(link_fail === 1'b0, "R10 link_fail held between reads",
          {15'd0, link_fail}, 16'h0);
    do_read(5'd3, 5'd0, 16'hFFFF, "R10 foreign read loads link_fail");

    wait_cycles(2);
    check(exp_data.size() == 0, "R11 all reads answered",
          16'(exp_data.size()), 16'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule